// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block decides, for a serial non-volatile memory, whether each modifying instruction may run. At the close of every chip-select frame the front end hands it the decoded instruction, the number of serial clock edges seen during the frame, the target address and, for a status write, the new status byte. The block owns the write enable latch, the busy flag and the status protection fields. Each modifying instruction gets one of two registered results: an execute strobe for the array engine, or a reject strobe.

An instruction is refused for any of these reasons: the power-up delay has not yet run out, an earlier instruction is still busy, the write enable latch is clear, the frame length is not a whole number of bytes, or the target lies in a protected region. A status write is also refused when the write-protect pin is low while the status-write-disable bit is set. Once the array engine signals completion, the busy flag drops and the latch clears. The memory array, the serial shifter, the read paths and program or erase timing are outside this block.

Top module: `wp_guard`

## Requirements
- R1: After `rst`, `wel`, `busy`, `sr_bp`, `sr_tb` and `sr_srwd` are 0 and `pwr_ready` is 0. `pwr_ready` rises PWR_DLY cycles after reset and then stays high. While it is low, no command changes `wel` and no command gives `exec_go`. A modifying command in that window gives `cmd_reject`.
- R2: Opcode 1 (write enable) sets `wel` and opcode 2 (write disable) clears it, provided `pwr_ready` is 1 and `busy` is 0. Opcode 0 and opcodes 9 to 15 have no effect.
- R3: Opcodes 3 (status write), 4 (page program), 5 (dual-input program), 6 (quad-input program), 7 (sector erase) and 8 (bulk erase) are modifying. Each gives `exec_go` only when `wel` is 1. Otherwise it gives `cmd_reject`.
- R4: A modifying command is rejected unless `cmd_edges` is nonzero and a multiple of eight.
- R5: An accepted command pulses `exec_go` for one cycle, with `exec_op` equal to its opcode, on the cycle after `cmd_valid`. `busy` then stays 1 until `op_done`.
- R6: `op_done` while `busy` is 1 clears both `busy` and `wel` on the next cycle. `op_done` while `busy` is 0 has no effect.
- R7: While `busy` is 1, commands are ignored: write enable and write disable leave `wel` unchanged, and modifying commands are rejected.
- R8: A rejected command leaves `wel` unchanged.
- R9: An accepted status write loads `cmd_sr[5:2]` into `sr_bp`, `cmd_sr[6]` into `sr_tb` and `cmd_sr[7]` into `sr_srwd`.
- R10: When `wp_n` is 0 and `sr_srwd` is 1, a status write is rejected with `prot_hit`, and the status fields keep their values.
- R11: When `sr_bp` = n ≥ 1, the protected region is the 2^(BLK_W+n−1) bytes at the top of the address space if `sr_tb` = 0, or at the bottom if `sr_tb` = 1. The region is capped at the whole array. When `sr_bp` = 0 nothing is protected. A program command (opcodes 4, 5, 6) whose address falls in the region is rejected with `prot_hit`.
- R12: A sector erase is rejected with `prot_hit` if any byte of its aligned 2^SEC_W sector is protected. A bulk erase is rejected with `prot_hit` whenever `sr_bp` ≠ 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | One-cycle strobe at chip-select rise |
| cmd_op | input | 4 | Decoded opcode |
| cmd_edges | input | CNT_W | Serial clock edges counted in the frame |
| cmd_addr | input | ADDR_W | Target address |
| cmd_sr | input | 8 | New status byte for a status write |
| op_done | input | 1 | Completion strobe from the array engine |
| pwr_ready | output | 1 | Power-up delay expired |
| wel | output | 1 | Write enable latch |
| busy | output | 1 | Accepted instruction in progress |
| exec_go | output | 1 | Execute strobe |
| exec_op | output | 4 | Opcode of the last accepted instruction |
| cmd_reject | output | 1 | Modifying command refused |
| prot_hit | output | 1 | Refusal caused by region or hardware protection |
| sr_bp | output | 4 | Block-protect level |
| sr_tb | output | 1 | Region anchor: 0 top, 1 bottom |
| sr_srwd | output | 1 | Status-write-disable bit |

## Verification
On every cycle, the assertions check the gating rules. A command seen with the latch clear, with a partial byte, while busy or before the power-up delay ends never yields an execute strobe. A status write under hardware protection never moves the status fields. Completion always clears the latch. The pulse that `pwr_ready` never drops is checked the same way. Only the bench scenarios show where the protected region lies for each block-protect level and anchor, the whole-sector overlap rule, and the exact values the status write loads.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_WREN = 4'd1,
    OP_WRDI = 4'd2,
    OP_WRSR = 4'd3,
    OP_PP   = 4'd4,
    OP_DPP  = 4'd5,
    OP_QPP  = 4'd6,
    OP_SE   = 4'd7,
    OP_BE   = 4'd8
  } wp_op_e;

  function automatic logic is_modifying(input wp_op_e op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_DPP) ||
           (op == OP_QPP) || (op == OP_SE) || (op == OP_BE);
  endfunction
endpackage

// File: rtl/wp_pwr_timer.sv
module wp_pwr_timer #(
  parameter int PWR_DLY = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int CW = $clog2(PWR_DLY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(PWR_DLY - 1)) ready <= 1'b1;
    end
  end

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
endmodule

// File: rtl/wp_region_chk.sv
module wp_region_chk #(
  parameter int ADDR_W = 24,
  parameter int BLK_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        bp,
  input  logic              tb,
  output logic              hit
);
  int                shamt;
  logic [ADDR_W-1:0] hmask;

  always_comb begin
    shamt = BLK_W + 32'(bp) - 1;
    for (int i = 0; i < ADDR_W; i++) hmask[i] = (i >= shamt);
    if (bp == 4'd0)
      hit = 1'b0;
    else if (tb)
      hit = ((addr & hmask) == '0);
    else
      hit = ((addr & hmask) == hmask);
  end
endmodule

// File: rtl/wp_state.sv
module wp_state
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  wp_op_e     op,
  input  logic [7:0] sr_in,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       rej_in,
  input  logic       prot_in,
  input  logic       op_done,
  output logic       wel,
  output logic       busy,
  output logic       exec_go,
  output logic [3:0] exec_op,
  output logic       cmd_reject,
  output logic       prot_hit,
  output logic [3:0] sr_bp,
  output logic       sr_tb,
  output logic       sr_srwd
);
  logic finish;
  assign finish = op_done && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel        <= 1'b0;
      busy       <= 1'b0;
      exec_go    <= 1'b0;
      exec_op    <= 4'd0;
      cmd_reject <= 1'b0;
      prot_hit   <= 1'b0;
      sr_bp      <= 4'd0;
      sr_tb      <= 1'b0;
      sr_srwd    <= 1'b0;
    end else begin
      exec_go    <= accept;
      cmd_reject <= rej_in;
      prot_hit   <= prot_in;
      if (accept) exec_op <= op;
      if (accept) busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (set_wel) wel <= 1'b1;
      else if (clr_wel || finish) wel <= 1'b0;
      if (accept && op == OP_WRSR) begin
        sr_bp   <= sr_in[5:2];
        sr_tb   <= sr_in[6];
        sr_srwd <= sr_in[7];
      end
    end
  end

  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (op_done && busy) |=> (!busy && !wel));
  // R5
  go_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    exec_go |-> $past(!busy));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BLK_W   = 16,
  parameter int SEC_W   = 16,
  parameter int CNT_W   = 16,
  parameter int PWR_DLY = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [CNT_W-1:0]  cmd_edges,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_sr,
  input  logic              op_done,
  output logic              pwr_ready,
  output logic              wel,
  output logic              busy,
  output logic              exec_go,
  output logic [3:0]        exec_op,
  output logic              cmd_reject,
  output logic              prot_hit,
  output logic [3:0]        sr_bp,
  output logic              sr_tb,
  output logic              sr_srwd
);
  localparam logic [ADDR_W-1:0] SEC_MSK = {{(ADDR_W-SEC_W){1'b0}}, {SEC_W{1'b1}}};

  wp_op_e            op;
  logic              take, is_mod, frame_ok, hpm, lo_hit, hi_hit, tgt_prot;
  logic              gate_ok, accept, rej, prot;
  logic [ADDR_W-1:0] lo_addr, hi_addr;

  assign op       = wp_op_e'(cmd_op);
  assign take     = cmd_valid && pwr_ready && !busy;
  assign is_mod   = is_modifying(op);
  assign frame_ok = (cmd_edges[2:0] == 3'd0) && (cmd_edges != '0);
  assign hpm      = !wp_n && sr_srwd;
  assign lo_addr  = (op == OP_SE) ? (cmd_addr & ~SEC_MSK) : cmd_addr;
  assign hi_addr  = (op == OP_SE) ? (cmd_addr | SEC_MSK) : cmd_addr;

  wp_pwr_timer #(.PWR_DLY(PWR_DLY)) u_tmr (.clk(clk), .rst(rst), .ready(pwr_ready));

  wp_region_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_lo (
    .addr(lo_addr), .bp(sr_bp), .tb(sr_tb), .hit(lo_hit));
  wp_region_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_hi (
    .addr(hi_addr), .bp(sr_bp), .tb(sr_tb), .hit(hi_hit));

  always_comb begin
    unique case (op)
      OP_PP, OP_DPP, OP_QPP, OP_SE: tgt_prot = lo_hit || hi_hit;
      OP_BE:   tgt_prot = (sr_bp != 4'd0);
      OP_WRSR: tgt_prot = hpm;
      default: tgt_prot = 1'b0;
    endcase
  end

  assign gate_ok = take && is_mod && wel && frame_ok;
  assign accept  = gate_ok && !tgt_prot;
  assign prot    = gate_ok && tgt_prot;
  assign rej     = cmd_valid && is_mod && !accept;

  wp_state u_st (
    .clk(clk), .rst(rst), .accept(accept), .op(op), .sr_in(cmd_sr),
    .set_wel(take && op == OP_WREN), .clr_wel(take && op == OP_WRDI),
    .rej_in(rej), .prot_in(prot), .op_done(op_done),
    .wel(wel), .busy(busy), .exec_go(exec_go), .exec_op(exec_op),
    .cmd_reject(cmd_reject), .prot_hit(prot_hit),
    .sr_bp(sr_bp), .sr_tb(sr_tb), .sr_srwd(sr_srwd));

  // R3
  no_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !wel) |=> !exec_go);
  // R4
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_edges[2:0] != 3'd0) |=> !exec_go);
  // R1
  pwr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !pwr_ready) |=> (!exec_go && $stable(wel)));
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> !exec_go);
  // R10
  hpm_lock_chk: assert property (@(posedge clk) disable iff (rst)
    hpm |=> ($stable(sr_bp) && $stable(sr_tb) && $stable(sr_srwd)));
  // R8
  rej_keep_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (rej && !(op_done && busy)) |=> $stable(wel));
endmodule

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
  localparam int AW = 16;
  localparam int CW = 12;

  logic clk = 1'b0, rst = 1'b1, wp_n = 1'b1, cmd_valid = 1'b0, op_done = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic [CW-1:0] cmd_edges = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_sr = 8'd0;
  logic pwr_ready, wel, busy, exec_go, cmd_reject, prot_hit, sr_tb, sr_srwd;
  logic [3:0] exec_op, sr_bp;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  wp_guard #(.ADDR_W(AW), .BLK_W(8), .SEC_W(12), .CNT_W(CW), .PWR_DLY(20)) u0 (
    .clk(clk), .rst(rst), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_edges(cmd_edges), .cmd_addr(cmd_addr), .cmd_sr(cmd_sr), .op_done(op_done),
    .pwr_ready(pwr_ready), .wel(wel), .busy(busy), .exec_go(exec_go), .exec_op(exec_op),
    .cmd_reject(cmd_reject), .prot_hit(prot_hit), .sr_bp(sr_bp), .sr_tb(sr_tb),
    .sr_srwd(sr_srwd));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int op, input int edges, input int addr, input int sr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_edges = CW'(edges);
    cmd_addr = AW'(addr); cmd_sr = 8'(sr);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0;
  endtask

  task automatic finish_op();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  // accepted / rejected check of one modifying command, then completion if accepted
  task automatic try_mod(input string tag, input int op, input int edges, input int addr,
                         input int sr, input bit ok, input bit ph);
    send(32'd1, 8, 0, 0);
    send(op, edges, addr, sr);
    chk({tag, " exec_go"}, int'(exec_go), int'(ok));
    chk({tag, " reject"}, int'(cmd_reject), int'(!ok));
    chk({tag, " prot_hit"}, int'(prot_hit), int'(ph));
    if (ok) begin
      chk({tag, " exec_op"}, int'(exec_op), op);
      finish_op();
      chk({tag, " wel cleared"}, int'(wel), 0);
    end else begin
      chk({tag, " wel kept (R8)"}, int'(wel), 1);
      send(32'd2, 8, 0, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 wel reset", int'(wel), 0);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 bp reset", int'(sr_bp), 0);
    chk("R1 srwd reset", int'(sr_srwd), 0);
    chk("R1 ready low", int'(pwr_ready), 0);
  endtask

  task automatic t_powerup();
    send(1, 8, 0, 0);
    chk("R1 wren ignored early", int'(wel), 0);
    send(4, 32, 0, 0);
    chk("R1 pp early reject", int'(cmd_reject), 1);
    chk("R1 pp early no exec", int'(exec_go), 0);
    repeat (22) @(negedge clk);
    chk("R1 ready high", int'(pwr_ready), 1);
  endtask

  task automatic t_latch();
    send(4, 32, 16'h1000, 0);
    chk("R3 no wel reject", int'(cmd_reject), 1);
    chk("R3 no wel no exec", int'(exec_go), 0);
    send(1, 8, 0, 0);
    chk("R2 wren sets", int'(wel), 1);
    send(0, 8, 0, 0);
    chk("R2 nop no effect", int'(wel), 1);
    send(2, 8, 0, 0);
    chk("R2 wrdi clears", int'(wel), 0);
    send(1, 8, 0, 0);
    send(9, 8, 0, 0);
    chk("R2 op9 no effect", int'(wel), 1);
    send(2, 8, 0, 0);
  endtask

  task automatic t_frame();
    try_mod("R4 pp 33 edges", 4, 33, 16'h1000, 0, 1'b0, 1'b0);
    try_mod("R4 se 0 edges", 7, 0, 16'h1000, 0, 1'b0, 1'b0);
    try_mod("R5 pp 40 edges", 4, 40, 16'h1000, 0, 1'b1, 1'b0);
    try_mod("R5 dpp", 5, 40, 16'h2000, 0, 1'b1, 1'b0);
    try_mod("R5 qpp", 6, 40, 16'h2000, 0, 1'b1, 1'b0);
  endtask

  task automatic t_busy();
    send(1, 8, 0, 0);
    send(7, 32, 16'h3000, 0);
    chk("R5 busy set", int'(busy), 1);
    send(4, 32, 16'h1000, 0);
    chk("R7 busy reject", int'(cmd_reject), 1);
    chk("R7 busy no exec", int'(exec_go), 0);
    send(2, 8, 0, 0);
    chk("R7 wrdi ignored", int'(wel), 1);
    repeat (3) @(negedge clk);
    chk("R5 busy held", int'(busy), 1);
    finish_op();
    chk("R6 busy cleared", int'(busy), 0);
    chk("R6 wel cleared", int'(wel), 0);
    send(1, 8, 0, 0);
    finish_op();
    chk("R6 idle done no effect", int'(wel), 1);
    send(2, 8, 0, 0);
  endtask

  task automatic t_regions();
    try_mod("R9 wrsr bp1 top", 3, 16, 0, 8'h04, 1'b1, 1'b0);
    chk("R9 bp loaded", int'(sr_bp), 1);
    chk("R9 tb loaded", int'(sr_tb), 0);
    try_mod("R11 pp top hit", 4, 32, 16'hFF10, 0, 1'b0, 1'b1);
    try_mod("R11 pp low ok", 4, 32, 16'h1000, 0, 1'b1, 1'b0);
    try_mod("R12 se overlap", 7, 32, 16'hF123, 0, 1'b0, 1'b1);
    try_mod("R12 se clear", 7, 32, 16'h0000, 0, 1'b1, 1'b0);
    try_mod("R12 be blocked", 8, 8, 0, 0, 1'b0, 1'b1);
    try_mod("R9 wrsr bp2 top", 3, 16, 0, 8'h08, 1'b1, 1'b0);
    try_mod("R11 pp FE00 hit", 4, 32, 16'hFE00, 0, 1'b0, 1'b1);
    try_mod("R11 pp FDFF ok", 4, 32, 16'hFDFF, 0, 1'b1, 1'b0);
    try_mod("R9 wrsr bp1 bottom", 3, 16, 0, 8'h44, 1'b1, 1'b0);
    chk("R9 tb set", int'(sr_tb), 1);
    try_mod("R11 pp bottom hit", 4, 32, 16'h0050, 0, 1'b0, 1'b1);
    try_mod("R11 pp top ok", 4, 32, 16'hFF10, 0, 1'b1, 1'b0);
    try_mod("R9 wrsr bp9", 3, 16, 0, 8'h24, 1'b1, 1'b0);
    try_mod("R11 all protected", 4, 32, 16'h1234, 0, 1'b0, 1'b1);
    try_mod("R9 wrsr clear", 3, 16, 0, 8'h00, 1'b1, 1'b0);
    try_mod("R12 be open", 8, 8, 0, 0, 1'b1, 1'b0);
  endtask

  task automatic t_hpm();
    try_mod("R9 wrsr srwd", 3, 16, 0, 8'h80, 1'b1, 1'b0);
    chk("R9 srwd loaded", int'(sr_srwd), 1);
    wp_n = 1'b0;
    try_mod("R10 hpm wrsr", 3, 16, 0, 8'h8C, 1'b0, 1'b1);
    chk("R10 bp kept", int'(sr_bp), 0);
    chk("R10 srwd kept", int'(sr_srwd), 1);
    wp_n = 1'b1;
    try_mod("R10 pin high wrsr", 3, 16, 0, 8'h0C, 1'b1, 1'b0);
    chk("R10 bp written", int'(sr_bp), 3);
    chk("R10 srwd written", int'(sr_srwd), 0);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_powerup();
    t_latch();
    t_frame();
    t_busy();
    t_regions();
    t_hpm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule